// File: doc/BRIEF.md
# Microstep Position Sequencer

This block keeps the electrical position of a two-coil stepper pair and turns it into a signed set-current ratio for each coil. A step input moves the position by one place per rising edge. The distance moved depends on which of four excitation modes is active, and the sign of the move depends on a direction control. The position is kept modulo 64 sub-steps per electrical cycle, which is 16 sub-steps per quadrant. Each coil ratio is given as a sign bit and a 10-bit magnitude in tenths of a percent. A downstream current regulator turns these ratios into coil currents.

The controls arrive already latched from a configuration register: mode, direction, step hold, counter run/park, output enable, monitor select and a chip enable. Direction and mode are sampled only on a step edge. Hold, park, output enable and chip enable act at once. An active-low monitor output marks the home position. In the finest mode it can instead mark every half-step position.

Top module: `ustep_seq`

## Requirements
- R1: After `rst_n` is released, the block is in 2-phase mode at its home position: coil 1 is +1000, coil 2 is -1000 and `mon_n` is 0.
- R2: Let `T(k)` for k = 0..16 be 0, 100, 200, 300, 395, 485, 575, 655, 740, 815, 855, 890, 930, 965, 1000, 1000, 1000. In the finest mode (`mode` = 2'b11), every position 0..63 is reachable, and the magnitudes come from `T` as described in R4.
- R3: `mode` = 2'b01 is half-step and uses only positions that are multiples of 8. `mode` = 2'b10 is full-torque half-step and uses the same positions, but magnitudes at positions of the form 16k+8 are forced to 1000. `mode` = 2'b00 is 2-phase and uses only positions 16k+8, where both magnitudes are 1000.
- R4: For position p, let r = p mod 16, q = p / 16, A = T(16-r) and B = T(r). The (coil 1, coil 2) ratios are (+A, -B) for q=0, (-B, -A) for q=1, (-A, +B) for q=2 and (+B, +A) for q=3. With `dir_ccw` = 1 a step raises p; with 0 it lowers p. Both wrap modulo 64.
- R5: A qualified rising edge on `step_in` changes the ratio outputs at the third rising clock edge after `step_in` first reads high. The index moves at no other time except a park.
- R6: On a qualified step edge, the new position is computed in two stages. First the old position is snapped to the mode then on `mode`: unchanged for 2'b11, forced to 16k+8 within its own 16-block for 2'b00, or rounded to the nearest multiple of 8 for the other two modes (ties round up). Then it moves by the stride of that mode (1, 8, 8 or 16). The same edge latches `mode` as the active mode.
- R7: While `hold` = 1, step edges are ignored. Releasing `hold` while `step_in` is already high causes no move; the next fresh rising edge does.
- R8: While `cnt_run` = 0, the outputs show the home position of the `mode` input in the same cycle: position 8 for 2'b00 and position 0 otherwise. `mon_n` is 0 and step edges are ignored. Once `cnt_run` returns to 1, the next step edge moves the index.
- R9: While `out_en` = 0, `c1_hiz` and `c2_hiz` are 1 but step edges still move the index. Once `out_en` returns to 1, the ratios of the advanced position appear.
- R10: While `chip_en` = 0, both hiz flags are 1 and step edges are ignored.
- R11: `mon_n` is 0 exactly at the home position of the active mode. The exception is the finest mode with `mon_sel` = 1, where `mon_n` is 0 at every multiple of 8. Outside the finest mode, `mon_sel` has no effect.
- R12: A sign bit is never 1 while its magnitude is 0, and no magnitude exceeds 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Step pulse, asynchronous to clk |
| chip_en | input | 1 | Chip enable; 0 = standby |
| mode | input | 2 | Excitation mode (00 2-phase, 10 full-torque half, 01 half, 11 finest) |
| dir_ccw | input | 1 | 1 = position increases, 0 = decreases |
| hold | input | 1 | 1 = ignore step edges |
| cnt_run | input | 1 | 0 = park at home position |
| out_en | input | 1 | 0 = flag both coils high-impedance |
| mon_sel | input | 1 | Monitor marks half-step positions in finest mode |
| c1_neg | output | 1 | Coil 1 sign |
| c1_mag | output | 10 | Coil 1 magnitude, 0.1 % units |
| c2_neg | output | 1 | Coil 2 sign |
| c2_mag | output | 10 | Coil 2 magnitude, 0.1 % units |
| c1_hiz | output | 1 | Coil 1 high-impedance flag |
| c2_hiz | output | 1 | Coil 2 high-impedance flag |
| mon_n | output | 1 | Active-low position monitor |

## Verification
A step result takes three clock edges to appear: two synchroniser flops and the index register. The bench drives `step_in` on a falling edge. It confirms the old ratios on the next two falling edges and the new ratios on the third. Every other sweep holds the pulse high and low for four cycles each, so the outputs have settled before they are sampled. Park, output enable, chip enable and monitor select reach the outputs combinationally, so their checks sample on the first falling edge after the control changes.

// File: rtl/ustep_seq.sv
module ustep_seq #(
  parameter int MAG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             chip_en,
  input  logic [1:0]       mode,
  input  logic             dir_ccw,
  input  logic             hold,
  input  logic             cnt_run,
  input  logic             out_en,
  input  logic             mon_sel,
  output logic             c1_neg,
  output logic [MAG_W-1:0] c1_mag,
  output logic             c2_neg,
  output logic [MAG_W-1:0] c2_mag,
  output logic             c1_hiz,
  output logic             c2_hiz,
  output logic             mon_n
);
  localparam int QW = 4;
  localparam int PW = QW + 2;
  localparam int HALF = 1 << (QW - 1);
  localparam logic [QW:0] QSPAN = (QW+1)'(1 << QW);
  localparam logic [MAG_W-1:0] FULL = MAG_W'(1000);

  function automatic logic [MAG_W-1:0] wave(input logic [QW:0] k);
    case (k)
      5'd0:  wave = MAG_W'(0);
      5'd1:  wave = MAG_W'(100);
      5'd2:  wave = MAG_W'(200);
      5'd3:  wave = MAG_W'(300);
      5'd4:  wave = MAG_W'(395);
      5'd5:  wave = MAG_W'(485);
      5'd6:  wave = MAG_W'(575);
      5'd7:  wave = MAG_W'(655);
      5'd8:  wave = MAG_W'(740);
      5'd9:  wave = MAG_W'(815);
      5'd10: wave = MAG_W'(855);
      5'd11: wave = MAG_W'(890);
      5'd12: wave = MAG_W'(930);
      5'd13: wave = MAG_W'(965);
      default: wave = FULL;
    endcase
  endfunction

  function automatic logic [PW-1:0] home(input logic [1:0] m);
    home = (m == 2'b00) ? PW'(HALF) : '0;
  endfunction

  function automatic logic [PW-1:0] snap(input logic [PW-1:0] p, input logic [1:0] m);
    case (m)
      2'b11:   snap = p;
      2'b00:   snap = {p[PW-1:QW], 1'b1, {(QW-1){1'b0}}};
      default: snap = (p + PW'(HALF/2)) & ~PW'(HALF-1);
    endcase
  endfunction

  function automatic logic [PW-1:0] stride(input logic [1:0] m);
    case (m)
      2'b11:   stride = PW'(1);
      2'b00:   stride = PW'(1 << QW);
      default: stride = PW'(HALF);
    endcase
  endfunction

  logic          s1, s2, s_prev, rise;
  logic [PW-1:0] pos, base, eff_pos;
  logic [1:0]    mode_q, eff_mode;

  assign rise = s2 & ~s_prev & ~hold & chip_en & cnt_run;
  assign base = snap(pos, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      s_prev <= 1'b0;
      pos    <= PW'(HALF);
      mode_q <= 2'b00;
    end else begin
      s1     <= step_in;
      s2     <= s1;
      s_prev <= s2;
      if (!cnt_run) begin
        pos    <= home(mode);
        mode_q <= mode;
      end else if (rise) begin
        pos    <= dir_ccw ? base + stride(mode) : base - stride(mode);
        mode_q <= mode;
      end
    end
  end

  assign eff_pos  = cnt_run ? pos : home(mode);
  assign eff_mode = cnt_run ? mode_q : mode;

  logic [QW-1:0]    r;
  logic [1:0]       q;
  logic [MAG_W-1:0] a, b, m1, m2;
  logic             n1, n2;

  assign r = eff_pos[QW-1:0];
  assign q = eff_pos[PW-1:QW];

  always_comb begin
    a = wave(QSPAN - {1'b0, r});
    b = wave({1'b0, r});
    if (!eff_mode[0] && r == QW'(HALF)) begin
      a = FULL;
      b = FULL;
    end
    case (q)
      2'd0: begin n1 = 1'b0; m1 = a; n2 = 1'b1; m2 = b; end
      2'd1: begin n1 = 1'b1; m1 = b; n2 = 1'b1; m2 = a; end
      2'd2: begin n1 = 1'b1; m1 = a; n2 = 1'b0; m2 = b; end
      default: begin n1 = 1'b0; m1 = b; n2 = 1'b0; m2 = a; end
    endcase
  end

  assign c1_mag = m1;
  assign c2_mag = m2;
  assign c1_neg = n1 & (m1 != '0);
  assign c2_neg = n2 & (m2 != '0);
  assign c1_hiz = ~(out_en & chip_en);
  assign c2_hiz = ~(out_en & chip_en);
  assign mon_n  = ~((eff_mode == 2'b11 && mon_sel) ? (eff_pos[QW-2:0] == '0)
                                                   : (eff_pos == home(eff_mode)));
endmodule

// File: rtl/ustep_seq_chk.sv
module ustep_seq_chk #(
  parameter int MAG_W = 10,
  parameter int PW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chip_en,
  input logic             hold,
  input logic             cnt_run,
  input logic             rise,
  input logic [1:0]       mode,
  input logic [1:0]       mode_q,
  input logic [PW-1:0]    pos,
  input logic             c1_neg,
  input logic [MAG_W-1:0] c1_mag,
  input logic [MAG_W-1:0] c2_mag,
  input logic             mon_n
);
  // R8
  park_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_run |-> (!mon_n && !c1_neg && c1_mag == MAG_W'(1000)));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && cnt_run) |=> $stable(pos));

  // R10
  standby_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en && cnt_run) |=> $stable(pos));

  // R5
  move_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> $past(rise || !cnt_run));

  // R2
  fine_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && mode == 2'b11 && mode_q == 2'b11) |=>
      ((pos - $past(pos)) == PW'(1) || ($past(pos) - pos) == PW'(1)));

  // R3
  two_phase_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_run && mode_q == 2'b00) |-> (c1_mag == MAG_W'(1000) && c2_mag == MAG_W'(1000)));

  // R12
  mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_mag <= MAG_W'(1000) && c2_mag <= MAG_W'(1000)));
endmodule

bind ustep_seq ustep_seq_chk #(.MAG_W(MAG_W), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .hold(hold), .cnt_run(cnt_run),
  .rise(rise), .mode(mode), .mode_q(mode_q), .pos(pos), .c1_neg(c1_neg),
  .c1_mag(c1_mag), .c2_mag(c2_mag), .mon_n(mon_n)
);

// File: tb/ustep_seq_bench.sv
module ustep_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, step_in, chip_en, dir_ccw, hold, cnt_run, out_en, mon_sel;
  logic [1:0] mode;
  logic c1_neg, c2_neg, c1_hiz, c2_hiz, mon_n;
  logic [9:0] c1_mag, c2_mag;

  ustep_seq u_ustep_seq (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .chip_en(chip_en), .mode(mode),
    .dir_ccw(dir_ccw), .hold(hold), .cnt_run(cnt_run), .out_en(out_en),
    .mon_sel(mon_sel), .c1_neg(c1_neg), .c1_mag(c1_mag), .c2_neg(c2_neg),
    .c2_mag(c2_mag), .c1_hiz(c1_hiz), .c2_hiz(c2_hiz), .mon_n(mon_n)
  );

  int total = 0, bad = 0;
  int mp;
  logic [1:0] mm;

  function automatic int tw(int k);
    case (k)
      0: return 0;    1: return 100;  2: return 200;  3: return 300;
      4: return 395;  5: return 485;  6: return 575;  7: return 655;
      8: return 740;  9: return 815;  10: return 855; 11: return 890;
      12: return 930; 13: return 965; default: return 1000;
    endcase
  endfunction

  function automatic int homeof(logic [1:0] m);
    return (m == 2'b00) ? 8 : 0;
  endfunction

  function automatic int snapm(int p, logic [1:0] m);
    if (m == 2'b11) return p;
    if (m == 2'b00) return (p / 16) * 16 + 8;
    return (((p + 4) / 8) * 8) % 64;
  endfunction

  function automatic int stridem(logic [1:0] m);
    if (m == 2'b11) return 1;
    if (m == 2'b00) return 16;
    return 8;
  endfunction

  function automatic int expc(int p, logic [1:0] m, bit second);
    int r, q, a, b, mag;
    bit neg;
    r = p % 16; q = p / 16;
    a = tw(16 - r); b = tw(r);
    if (m[0] == 1'b0 && r == 8) begin a = 1000; b = 1000; end
    case (q)
      0: begin neg = second;  mag = second ? b : a; end
      1: begin neg = 1'b1;    mag = second ? a : b; end
      2: begin neg = !second; mag = second ? b : a; end
      default: begin neg = 1'b0; mag = second ? a : b; end
    endcase
    return (neg && mag != 0) ? 10000 + mag : mag;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d mode %0d)", tag, act, exp, mp, mm);
    end
  endtask

  task automatic check_ratio(string tag);
    chk({tag, " coil1"}, (c1_neg ? 10000 : 0) + int'(c1_mag), expc(mp, mm, 1'b0));
    chk({tag, " coil2"}, (c2_neg ? 10000 : 0) + int'(c2_mag), expc(mp, mm, 1'b1));
  endtask

  task automatic check_mon(string tag);
    bit low;
    low = !cnt_run || ((mm == 2'b11 && mon_sel) ? (mp % 8 == 0) : (mp == homeof(mm)));
    chk({tag, " mon"}, int'(mon_n), low ? 0 : 1);
  endtask

  task automatic pulse();
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    if (chip_en && cnt_run && !hold) begin
      mp = dir_ccw ? (snapm(mp, mode) + stridem(mode)) % 64
                   : (snapm(mp, mode) - stridem(mode) + 64) % 64;
      mm = mode;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; step_in = 1'b0; chip_en = 1'b1; dir_ccw = 1'b0; hold = 1'b0;
    cnt_run = 1'b1; out_en = 1'b1; mon_sel = 1'b0; mode = 2'b00;
    mp = 8; mm = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check_ratio("R1 reset");
    check_mon("R1 reset");

    // R5 latency: old on two falling edges, new on the third
    mode = 2'b11; dir_ccw = 1'b1;
    step_in = 1'b1;
    @(negedge clk); check_ratio("R5 edge1");
    @(negedge clk); check_ratio("R5 edge2");
    @(negedge clk);
    mp = snapm(mp, mode) + 1; mm = mode;
    check_ratio("R5 edge3");
    step_in = 1'b0;
    repeat (4) @(negedge clk);

    // R2 / R4 / R12 full sweep of finest mode both directions
    for (int i = 0; i < 64; i++) begin pulse(); check_ratio("R2 R4 R12 ccw"); end
    dir_ccw = 1'b0;
    for (int i = 0; i < 64; i++) begin pulse(); check_ratio("R2 R4 R12 cw"); end

    // R3 coarse modes
    for (int k = 0; k < 3; k++) begin
      mode = (k == 0) ? 2'b01 : (k == 1) ? 2'b10 : 2'b00;
      for (int d = 0; d < 2; d++) begin
        dir_ccw = d[0];
        for (int i = 0; i < 9; i++) begin pulse(); check_ratio("R3 coarse"); end
      end
    end

    // R6 remap from every finest sub-position
    for (int off = 1; off < 16; off++) begin
      mode = 2'b11; dir_ccw = 1'b1;
      for (int i = 0; i < off; i++) pulse();
      mode = (off % 3 == 0) ? 2'b00 : (off % 3 == 1) ? 2'b01 : 2'b10;
      dir_ccw = off[0];
      pulse();
      check_ratio("R6 remap");
    end

    // R7 hold
    mode = 2'b11; dir_ccw = 1'b1; pulse();
    hold = 1'b1;
    repeat (3) pulse();
    check_ratio("R7 held");
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    hold = 1'b0;
    repeat (5) @(negedge clk);
    check_ratio("R7 release high");
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    pulse();
    check_ratio("R7 next edge");

    // R8 park
    cnt_run = 1'b0; mp = homeof(mode); mm = mode;
    @(negedge clk);
    check_ratio("R8 park"); check_mon("R8 park");
    mode = 2'b00; mp = 8; mm = 2'b00;
    @(negedge clk);
    check_ratio("R8 park 2ph");
    pulse();
    check_ratio("R8 ignored");
    cnt_run = 1'b1; mode = 2'b11;
    repeat (2) @(negedge clk);
    check_ratio("R8 released");
    pulse();
    check_ratio("R8 moves");

    // R9 output enable
    out_en = 1'b0;
    @(negedge clk);
    chk("R9 hiz1", int'(c1_hiz), 1); chk("R9 hiz2", int'(c2_hiz), 1);
    repeat (3) pulse();
    out_en = 1'b1;
    @(negedge clk);
    chk("R9 hiz1 off", int'(c1_hiz), 0); chk("R9 hiz2 off", int'(c2_hiz), 0);
    check_ratio("R9 advanced");

    // R10 chip enable
    chip_en = 1'b0;
    @(negedge clk);
    chk("R10 hiz1", int'(c1_hiz), 1); chk("R10 hiz2", int'(c2_hiz), 1);
    repeat (3) pulse();
    chip_en = 1'b1;
    @(negedge clk);
    check_ratio("R10 unchanged");

    // R11 monitor
    mon_sel = 1'b1;
    for (int i = 0; i < 20; i++) begin pulse(); check_mon("R11 fine sel"); end
    mon_sel = 1'b0;
    for (int i = 0; i < 20; i++) begin pulse(); check_mon("R11 fine home"); end
    mode = 2'b01; mon_sel = 1'b1;
    for (int i = 0; i < 10; i++) begin pulse(); check_mon("R11 half sel ignored"); end
    mode = 2'b00;
    for (int i = 0; i < 6; i++) begin pulse(); check_mon("R11 2ph"); end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule